// File: doc/BRIEF.md
# Page Access Guard with Fault Status Capture

This block sits behind a page-table walker and decides, for one translated access, whether the access may proceed. It takes the access kind (data read, data write or instruction fetch), the privilege mode and the 3-bit permission field of the final page entry. From these it produces a fault classification and the read/write/execute rights that may be cached for the page. Write rights are withheld until the page entry reports that the page has already been modified. The walker must then perform a modifying access to set that bit.

Every fault is recorded in an 8-bit fault status register and a page-aligned fault address register. A second fault that arrives before software has read the status sets an overflow flag. A read of the status register returns the current value and clears the register at the same clock edge. When the no-fault mode is on or traps are disabled, a fault is still recorded. In that case no trap is raised and the access is granted full rights. Otherwise an instruction-fetch fault raises the instruction trap and any other fault raises the data trap.

Top module: `mmu_access_guard`

## Requirements
- R1: The access index is 3 bits: bit 2 is set for a write, bit 1 for an instruction fetch and bit 0 for supervisor mode. Kind encoding on `req_kind`: 2'b00 read, 2'b01 write, 2'b10 fetch, and 2'b11 behaves exactly as a read. The index is recorded in status bits [7:5].
- R2: A user-mode access (`req_super`=0) with permission 6 or 7 is a privilege fault with code 12, recorded as status bits [4:2] = 3'b011.
- R3: In all other cases an access is a protection fault with code 8 (status bits [4:2] = 3'b010) when the right it needs (R for read, W for write, X for fetch) is absent from the rights of R4.
- R4: Rights per permission value 0..4 are R, RW, RX, RWX and X. For 5, 6 and 7 they are RW, RX and RWX in supervisor mode, and R, none and none in user mode. On a non-faulting valid access, `grant` gives these rights with bit 0 = R, bit 1 = W and bit 2 = X.
- R5: On a non-faulting access, the W bit of `grant` is 0 whenever `req_modified` is 0.
- R6: On a fault, the next status is formed as follows. If the old status was non-zero and is not being read, it first collapses to 8'h01 (the overflow bit); otherwise it starts from zero. The access index, the fault code and the address-valid bit 1 are then ORed in. A valid access that does not fault leaves the status unchanged.
- R7: On a fault, `far_q` captures `req_vaddr` with its low PAGE_SHIFT bits forced to zero. Without a fault it holds its value.
- R8: A fault raises `trap_inst` for a fetch and `trap_data` otherwise, but only when `traps_en`=1 and `nofault_en`=0. At most one trap is high at a time.
- R9: A fault with `nofault_en`=1 or `traps_en`=0 gives `grant` = 3'b111. A trapping fault gives `grant` = 3'b000. `fault` is high for every faulting valid access.
- R10: While `fsr_rd` is high, `fsr_rdata` shows the current status and the register clears at that edge. A fault in the same cycle is merged onto zero, so no overflow is set.
- R11: After reset the status and address registers are zero. With `req_valid`=0, `grant`, `fault` and both traps are 0 and no register changes except through a status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | An access is presented for checking this cycle |
| req_kind | input | 2 | Access kind: 00 read, 01 write, 10 fetch, 11 read |
| req_super | input | 1 | Access is made in supervisor mode |
| req_perm | input | 3 | Permission field of the translated page entry |
| req_modified | input | 1 | Page entry's modified bit |
| req_vaddr | input | VA_W | Virtual address of the access |
| nofault_en | input | 1 | No-fault mode: record faults but raise no trap |
| traps_en | input | 1 | Traps are enabled |
| grant | output | 3 | Cacheable rights: bit0 R, bit1 W, bit2 X |
| fault | output | 1 | The presented access faults |
| trap_inst | output | 1 | Instruction-fetch fault trap request |
| trap_data | output | 1 | Data fault trap request |
| fsr_rd | input | 1 | Status register read strobe (clear on read) |
| fsr_rdata | output | 8 | Fault status register value |
| far_q | output | VA_W | Page-aligned fault address register |

## Verification
The embedded assertions check on every cycle that a fault always sets the address-valid bit and that an unread fault sets the overflow bit. They also check that a read without a fault clears the status, that a read merged with a fault leaves overflow clear, and that the address register holds when there is no fault. Further per-cycle checks cover the traps being mutually exclusive and gated by the enables, and a granted write never appearing on an unmodified page. The fault matrix itself, the exact rights per mode and permission, the exact status encoding and the address alignment can only be shown by the bench. It does this with a sweep over every kind, mode, permission, modified bit and enable combination, followed by a directed sequence of back-to-back faults.

// File: rtl/mmu_guard_pkg.sv
package mmu_guard_pkg;

   typedef enum logic [1:0] {
      KIND_READ  = 2'b00,
      KIND_WRITE = 2'b01,
      KIND_FETCH = 2'b10,
      KIND_RSVD  = 2'b11
   } acc_kind_e;

   // Rights vector: r is the LSB, x the MSB
   typedef struct packed {
      logic x;
      logic w;
      logic r;
   } rights_t;

   localparam int FSR_W    = 8;
   localparam int CODE_W   = 4;
   localparam int AIDX_W   = 3;

   localparam logic [CODE_W-1:0] CODE_OK   = 4'd0;
   localparam logic [CODE_W-1:0] CODE_PROT = 4'd8;
   localparam logic [CODE_W-1:0] CODE_PRIV = 4'd12;

   // Access index: [2] write, [1] fetch, [0] supervisor
   function automatic logic [AIDX_W-1:0] make_aidx(input acc_kind_e kind,
                                                   input logic     sup);
      return {kind == KIND_WRITE, kind == KIND_FETCH, sup};
   endfunction

endpackage

// File: rtl/mmu_rights_decode.sv
module mmu_rights_decode
   import mmu_guard_pkg::*;
#(
   parameter int PERM_W = 3
) (
   input  logic [PERM_W-1:0] perm,
   input  logic              is_user,
   output rights_t           rights
);

   generate
      if (PERM_W != 3) begin : g_bad_perm
         $error("mmu_rights_decode: PERM_W must be 3");
      end
   endgenerate

   logic [2:0] xwr;

   // Rights by permission value, bit order {x,w,r}
   always_comb begin
      unique case (perm)
         3'd0:    xwr = 3'b001;
         3'd1:    xwr = 3'b011;
         3'd2:    xwr = 3'b101;
         3'd3:    xwr = 3'b111;
         3'd4:    xwr = 3'b100;
         3'd5:    xwr = is_user ? 3'b001 : 3'b011;
         3'd6:    xwr = is_user ? 3'b000 : 3'b101;
         default: xwr = is_user ? 3'b000 : 3'b111;
      endcase
   end

   assign rights = rights_t'(xwr);

endmodule

// File: rtl/mmu_fault_classify.sv
module mmu_fault_classify
   import mmu_guard_pkg::*;
#(
   parameter int PERM_W = 3
) (
   input  acc_kind_e           kind,
   input  logic                is_user,
   input  logic [PERM_W-1:0]   perm,
   input  rights_t             rights,
   output logic [CODE_W-1:0]   code
);

   logic priv_hit;
   logic need_ok;

   // User mode may never touch the two supervisor-only encodings
   assign priv_hit = is_user && perm[PERM_W-1] && perm[PERM_W-2];

   always_comb begin
      unique case (kind)
         KIND_WRITE: need_ok = rights.w;
         KIND_FETCH: need_ok = rights.x;
         default:    need_ok = rights.r;
      endcase
   end

   always_comb begin
      if (priv_hit)      code = CODE_PRIV;
      else if (!need_ok) code = CODE_PROT;
      else               code = CODE_OK;
   end

endmodule

// File: rtl/mmu_fault_regs.sv
module mmu_fault_regs
   import mmu_guard_pkg::*;
#(
   parameter int VA_W       = 32,
   parameter int PAGE_SHIFT = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                fault_evt,
   input  logic [AIDX_W-1:0]   aidx,
   input  logic [CODE_W-1:0]   code,
   input  logic [VA_W-1:0]     vaddr,
   input  logic                rd,
   output logic [FSR_W-1:0]    fsr_q,
   output logic [VA_W-1:0]     far_q
);

   localparam logic [VA_W-1:0] PG_MASK = {VA_W{1'b1}} << PAGE_SHIFT;

   generate
      if (PAGE_SHIFT < 0 || PAGE_SHIFT >= VA_W) begin : g_bad_shift
         $error("mmu_fault_regs: PAGE_SHIFT out of range");
      end
      if (FSR_W != AIDX_W + CODE_W + 1) begin : g_bad_fsr
         $error("mmu_fault_regs: status layout does not fit");
      end
   endgenerate

   logic [FSR_W-1:0] fsr_base;
   logic [FSR_W-1:0] fsr_new;
   logic [FSR_W-1:0] fsr_d;
   logic [VA_W-1:0]  far_d;

   // Status layout: [7:5] access index, [4:2] code>>2, [1] valid, [0] overflow
   always_comb begin
      fsr_base = '0;
      if (!rd && (fsr_q != '0)) fsr_base = {{(FSR_W-1){1'b0}}, 1'b1};
      fsr_new  = fsr_base | {aidx, 1'b0, code[CODE_W-1:2], 2'b10};
      if (fault_evt)   fsr_d = fsr_new;
      else if (rd)     fsr_d = '0;
      else             fsr_d = fsr_q;
   end

   assign far_d = fault_evt ? (vaddr & PG_MASK) : far_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fsr_q <= '0;
         far_q <= '0;
      end else begin
         fsr_q <= fsr_d;
         far_q <= far_d;
      end
   end

   assert_fav_after_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fault_evt |=> fsr_q[1]);

   assert_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_evt && !rd && (fsr_q != '0)) |=> fsr_q[0]);

   assert_clear_on_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !fault_evt) |=> (fsr_q == '0));

   assert_no_ovf_after_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && fault_evt) |=> !fsr_q[0]);

   assert_far_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !fault_evt |=> $stable(far_q));

endmodule

// File: rtl/mmu_access_guard.sv
module mmu_access_guard
   import mmu_guard_pkg::*;
#(
   parameter int VA_W       = 32,
   parameter int PAGE_SHIFT = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_kind,
   input  logic              req_super,
   input  logic [2:0]        req_perm,
   input  logic              req_modified,
   input  logic [VA_W-1:0]   req_vaddr,
   input  logic              nofault_en,
   input  logic              traps_en,
   output logic [2:0]        grant,
   output logic              fault,
   output logic              trap_inst,
   output logic              trap_data,
   input  logic              fsr_rd,
   output logic [7:0]        fsr_rdata,
   output logic [VA_W-1:0]   far_q
);

   generate
      if (VA_W < 8) begin : g_bad_va
         $error("mmu_access_guard: VA_W too small");
      end
   endgenerate

   acc_kind_e          kind;
   logic               is_user;
   rights_t            rights;
   logic [CODE_W-1:0]  code;
   logic [AIDX_W-1:0]  aidx;
   logic               fault_raw;
   logic               fault_evt;
   logic               trap_ok;
   logic [FSR_W-1:0]   fsr_q;

   assign kind    = acc_kind_e'(req_kind);
   assign is_user = !req_super;
   assign aidx    = make_aidx(kind, req_super);

   mmu_rights_decode #(.PERM_W(3)) u_rights (
      .perm    (req_perm),
      .is_user (is_user),
      .rights  (rights)
   );

   mmu_fault_classify #(.PERM_W(3)) u_classify (
      .kind    (kind),
      .is_user (is_user),
      .perm    (req_perm),
      .rights  (rights),
      .code    (code)
   );

   assign fault_raw = (code != CODE_OK);
   assign fault_evt = req_valid && fault_raw;
   assign trap_ok   = traps_en && !nofault_en;

   always_comb begin
      grant = 3'b000;
      if (req_valid) begin
         if (fault_raw) grant = trap_ok ? 3'b000 : 3'b111;
         else           grant = {rights.x, rights.w & req_modified, rights.r};
      end
   end

   assign fault     = fault_evt;
   assign trap_inst = fault_evt && trap_ok && (kind == KIND_FETCH);
   assign trap_data = fault_evt && trap_ok && (kind != KIND_FETCH);

   mmu_fault_regs #(.VA_W(VA_W), .PAGE_SHIFT(PAGE_SHIFT)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .fault_evt (fault_evt),
      .aidx      (aidx),
      .code      (code),
      .vaddr     (req_vaddr),
      .rd        (fsr_rd),
      .fsr_q     (fsr_q),
      .far_q     (far_q)
   );

   assign fsr_rdata = fsr_q;

   assert_trap_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({trap_inst, trap_data}));

   assert_trap_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_inst || trap_data) |-> (fault && traps_en && !nofault_en));

   assert_write_needs_mod_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !fault && grant[1]) |-> req_modified);

   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> ((grant == 3'b000) && !fault && !trap_inst && !trap_data));

   assert_priv_fault_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_super && req_perm[2] && req_perm[1]) |=> fsr_rdata[3:2] == 2'b11);

endmodule

// File: tb/mmu_access_guard_tb.sv
module mmu_access_guard_tb;

   localparam int CLK_PERIOD = 10;
   localparam int VA_W = 32;

   logic clk = 1'b0;
   logic rst_n;
   logic req_valid, req_super, req_modified, nofault_en, traps_en, fsr_rd;
   logic [1:0] req_kind;
   logic [2:0] req_perm;
   logic [VA_W-1:0] req_vaddr;
   logic [2:0] grant;
   logic fault, trap_inst, trap_data;
   logic [7:0] fsr_rdata;
   logic [VA_W-1:0] far_q;

   int checks = 0;
   int errors = 0;
   logic [31:0] far_exp = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mmu_access_guard #(.VA_W(VA_W), .PAGE_SHIFT(12)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_super(req_super), .req_perm(req_perm), .req_modified(req_modified),
      .req_vaddr(req_vaddr), .nofault_en(nofault_en), .traps_en(traps_en),
      .grant(grant), .fault(fault), .trap_inst(trap_inst), .trap_data(trap_data),
      .fsr_rd(fsr_rd), .fsr_rdata(fsr_rdata), .far_q(far_q)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Independent model: returns {code[3:0]} and rights {x,w,r}
   function automatic logic [3:0] exp_code(input int k, input int s, input int p);
      logic user, r, w, x, need;
      user = (s == 0);
      r = (p != 4) && !(user && p >= 6);
      w = (p % 2 == 1) && !(user && p >= 5);
      x = ((p / 2) % 2 == 1 || p == 4) && !(user && p >= 6);
      need = (k == 1) ? w : (k == 2) ? x : r;
      if (user && p >= 6) return 4'd12;
      return need ? 4'd0 : 4'd8;
   endfunction

   function automatic logic [2:0] exp_rights(input int s, input int p);
      logic user, r, w, x;
      user = (s == 0);
      r = (p != 4) && !(user && p >= 6);
      w = (p % 2 == 1) && !(user && p >= 5);
      x = ((p / 2) % 2 == 1 || p == 4) && !(user && p >= 6);
      return {x, w, r};
   endfunction

   function automatic logic [7:0] fsr_of(input int k, input int s, input logic [3:0] c);
      logic [2:0] ai;
      ai = {k == 1, k == 2, s == 1};
      return {ai, 1'b0, c[3:2], 2'b10};
   endfunction

   task automatic drive(input logic v, input int k, input int s, input int p,
                        input logic m, input logic n, input logic t,
                        input logic rd, input logic [31:0] va);
      req_valid = v; req_kind = 2'(k); req_super = (s != 0); req_perm = 3'(p);
      req_modified = m; nofault_en = n; traps_en = t; fsr_rd = rd; req_vaddr = va;
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      drive(0, 0, 0, 0, 0, 0, 0, 0, '0);
      repeat (3) @(posedge clk);
      #1;
      chk("R11 reset fsr", 32'(fsr_rdata), 32'h0);
      chk("R11 reset far", far_q, 32'h0);
      chk("R11 idle grant", 32'(grant), 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // Exhaustive sweep
      for (int idx = 0; idx < 512; idx++) begin
         int k, s, p;
         logic m, n, t, f, ovr;
         logic [3:0] c;
         logic [2:0] g;
         logic [31:0] va;
         k = idx % 4; s = (idx / 4) % 2; p = (idx / 8) % 8;
         m = 1'((idx / 64) % 2); n = 1'((idx / 128) % 2); t = 1'((idx / 256) % 2);
         va = 32'h9E3779B9 * 32'(idx + 1);
         c = exp_code(k, s, p);
         f = (c != 4'd0);
         ovr = n || !t;
         if (!f) g = exp_rights(s, p) & {1'b1, m, 1'b1};
         else    g = ovr ? 3'b111 : 3'b000;
         @(negedge clk);
         drive(1, k, s, p, m, n, t, 1, va);
         #1;
         if (f) chk("R9 grant on fault", 32'(grant), 32'(g));
         else if (!m) chk("R5 grant unmodified", 32'(grant), 32'(g));
         else chk("R4 grant rights", 32'(grant), 32'(g));
         if (c == 4'd12) chk("R2 priv fault", 32'(fault), 32'(f));
         else chk("R3 prot fault", 32'(fault), 32'(f));
         chk("R8 trap_inst", 32'(trap_inst), 32'(f && !ovr && k == 2));
         chk("R8 trap_data", 32'(trap_data), 32'(f && !ovr && k != 2));
         if (f) far_exp = va & 32'hFFFF_F000;
         @(negedge clk);
         drive(0, 0, 0, 0, 0, 0, 0, 1, 32'h0);
         #1;
         chk("R1 R6 status", 32'(fsr_rdata), f ? 32'(fsr_of(k, s, c)) : 32'h0);
         chk("R7 far", far_q, far_exp);
         chk("R11 idle quiet", 32'({grant, fault, trap_inst, trap_data}), 32'h0);
      end

      // Overflow and read/fault ordering
      @(negedge clk);
      drive(1, 0, 0, 4, 1, 0, 1, 0, 32'h1234_5678);   // user read perm4: prot
      @(negedge clk);
      #1;
      chk("R10 cleared by prior read", 32'(fsr_rdata), 32'h0A);
      chk("R7 far first", far_q, 32'h1234_5000);
      drive(1, 1, 1, 0, 1, 0, 1, 0, 32'hCAFE_BABE);   // super write perm0: prot
      @(negedge clk);
      #1;
      chk("R6 overflow set", 32'(fsr_rdata), 32'hAB);
      chk("R7 far second", far_q, 32'hCAFE_B000);
      drive(1, 2, 0, 7, 1, 0, 1, 0, 32'h0000_0FFF);   // user fetch perm7: priv
      @(negedge clk);
      #1;
      chk("R2 R6 overflow priv", 32'(fsr_rdata), 32'h4F);
      chk("R7 far third", far_q, 32'h0000_0000);
      drive(1, 0, 1, 3, 1, 0, 1, 0, 32'hFFFF_FFFF);   // super read perm3: ok
      @(negedge clk);
      #1;
      chk("R6 hold on ok access", 32'(fsr_rdata), 32'h4F);
      chk("R7 far hold", far_q, 32'h0000_0000);
      drive(1, 1, 0, 0, 1, 0, 1, 1, 32'h8000_1000);   // user write perm0 with read
      #1;
      chk("R10 read shows value", 32'(fsr_rdata), 32'h4F);
      @(negedge clk);
      #1;
      chk("R10 fault merged after read", 32'(fsr_rdata), 32'h8A);
      chk("R7 far fourth", far_q, 32'h8000_1000);
      drive(0, 0, 0, 0, 0, 0, 0, 1, 32'h0);
      @(negedge clk);
      #1;
      chk("R10 clear on read", 32'(fsr_rdata), 32'h0);
      drive(1, 3, 0, 4, 1, 1, 1, 0, 32'h0000_2000);   // kind 3 as read, nofault
      #1;
      chk("R1 R9 reserved kind grant", 32'(grant), 32'h7);
      chk("R8 nofault no trap", 32'({trap_inst, trap_data}), 32'h0);
      @(negedge clk);
      #1;
      chk("R1 reserved kind index", 32'(fsr_rdata), 32'h0A);
      drive(0, 0, 0, 0, 0, 0, 0, 0, 32'h0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule